// File: doc/BRIEF.md
# Two-Phase to Four-Phase Handshake Bridge

This block joins a sender that uses transition signalling to a receiver that uses level signalling. On the sender side, every change of the request wire, rising or falling, announces one new data word, and the block answers with exactly one change of its acknowledge wire. On the receiver side, each word is carried by one full return-to-zero cycle in a fixed order: the request rises, the acknowledge rises, the request falls, and the acknowledge falls.

The block is a clocked model. Its handshake inputs are taken as already synchronized to the clock, and all flops use a synchronous active-low reset. A sender event is found by comparing the request level with a stored copy of the level last accepted. The data word is latched when the event is accepted. It is held unchanged on the receiver side until the four-phase cycle has fully returned to zero. Only after that is the sender's acknowledge toggled.

Top module: `hs2to4_bridge`

## Requirements
- R1: During and right after reset, `lv_req` and `tr_ack` are 0 and the stored request copy takes the current `tr_req` level, so no cycle starts after reset whatever level `tr_req` holds.
- R2: A change of `tr_req` in either direction, seen while idle, drives `lv_req` to 1 at the next clock edge.
- R3: Once `lv_req` is 1, it stays 1 until `lv_ack` is sampled 1. It then goes to 0 at the next clock edge.
- R4: `tr_ack` toggles exactly once per accepted event. The toggle comes at the clock edge after `lv_ack` is sampled 0 following the fall of `lv_req`, and never earlier.
- R5: `lv_data` equals the `tr_data` value present at the edge that accepted the event. It stays unchanged until `tr_ack` toggles, even if `tr_data` changes meanwhile.
- R6: Changes of `lv_ack` while the block is idle have no effect on `lv_req` or `tr_ack`.
- R7: While `tr_req` keeps its level, `lv_req` stays 0; `lv_req` only rises after a sampled event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tr_req | input | 1 | Transition-signalled request from the sender |
| tr_data | input | DW | Data word bundled with `tr_req` |
| tr_ack | output | 1 | Transition-signalled acknowledge to the sender |
| lv_req | output | 1 | Level-signalled request to the receiver |
| lv_ack | input | 1 | Level-signalled acknowledge from the receiver |
| lv_data | output | DW | Held data word for the receiver |

## Verification
The bench sends words on both rising and falling request edges, so a design that spots only one edge direction leaves a queued word unanswered. The receiver model holds its acknowledge high for several cycles and checks that `tr_ack` has not moved yet. A design that toggles on the acknowledge rise instead of after the return to zero is caught there. The model also changes `tr_data` mid-cycle to catch a transparent data path. Idle acknowledge pulses and a reset taken with the request high check that no spurious cycle appears.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RAISE = 2'd1,
    PH_DROP  = 2'd2
  } phase_e;

  // A two-phase event is any difference between the live level and the last accepted one.
  function automatic logic is_transition(input logic cur, input logic prev);
    return cur ^ prev;
  endfunction

  function automatic phase_e next_phase(input phase_e ph, input logic evt, input logic ack);
    phase_e n;
    n = ph;
    case (ph)
      PH_IDLE:  if (evt) n = PH_RAISE;
      PH_RAISE: if (ack) n = PH_DROP;
      PH_DROP:  if (!ack) n = PH_IDLE;
      default:  n = PH_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/hs_event_detect.sv
module hs_event_detect
  import hs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tr_req,
  input  logic take,
  output logic evt
);

  logic req_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)    req_seen <= tr_req;
    else if (take) req_seen <= tr_req;
  end

  assign evt = is_transition(tr_req, req_seen);

  AST_TAKE_CLEARS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (req_seen == $past(tr_req))); // R2

endmodule

// File: rtl/hs_phase_seq.sv
module hs_phase_seq
  import hs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic lv_ack,
  output logic lv_req,
  output logic tr_ack,
  output logic take,
  output logic busy
);

  phase_e ph, ph_nx;

  assign ph_nx = next_phase(ph, evt, lv_ack);
  assign take  = (ph == PH_IDLE) && evt;
  assign busy  = (ph != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      lv_req <= 1'b0;
      tr_ack <= 1'b0;
    end else begin
      ph <= ph_nx;
      if (ph == PH_IDLE && ph_nx == PH_RAISE) lv_req <= 1'b1;
      if (ph == PH_RAISE && ph_nx == PH_DROP) lv_req <= 1'b0;
      if (ph == PH_DROP && ph_nx == PH_IDLE)  tr_ack <= ~tr_ack;
    end
  end

  AST_RISE_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> lv_req); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lv_req && !lv_ack) |=> lv_req); // R3

  AST_FALL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (lv_req && lv_ack) |=> !lv_req); // R3

  AST_ACK_AFTER_RTZ: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_ack != $past(tr_ack)) |-> (!$past(lv_ack) && !$past(lv_req) && $past(busy))); // R4

  AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !evt) |=> (!lv_req && $stable(tr_ack))); // R6

  AST_NO_SPURIOUS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lv_req) |-> $past(evt)); // R7

endmodule

// File: rtl/hs_data_hold.sv
module hs_data_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          busy,
  input  logic [DW-1:0] d_in,
  output logic [DW-1:0] d_out
);

  always_ff @(posedge clk) begin
    if (!rst_n)    d_out <= '0;
    else if (take) d_out <= d_in;
  end

  AST_DATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (d_out == $past(d_in))); // R5

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(d_out)); // R5

endmodule

// File: rtl/hs2to4_bridge.sv
module hs2to4_bridge #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tr_req,
  input  logic [DW-1:0] tr_data,
  output logic          tr_ack,
  output logic          lv_req,
  input  logic          lv_ack,
  output logic [DW-1:0] lv_data
);

  logic evt;
  logic take;
  logic busy;

  hs_event_detect u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .tr_req(tr_req),
    .take  (take),
    .evt   (evt)
  );

  hs_phase_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt),
    .lv_ack(lv_ack),
    .lv_req(lv_req),
    .tr_ack(tr_ack),
    .take  (take),
    .busy  (busy)
  );

  hs_data_hold #(.DW(DW)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .take (take),
    .busy (busy),
    .d_in (tr_data),
    .d_out(lv_data)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!lv_req && !tr_ack)); // R1

endmodule

// File: tb/hs2to4_bridge_tb.sv
module hs2to4_bridge_tb;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tr_req = 1'b0;
  logic [DW-1:0] tr_data = '0;
  logic          tr_ack;
  logic          lv_req;
  logic          lv_ack = 1'b0;
  logic [DW-1:0] lv_data;

  int checks = 0;
  int errors = 0;
  int served = 0;
  int sent = 0;
  int cycles = 0;
  logic [DW-1:0] exp_q[$];

  always #5 clk = ~clk;

  hs2to4_bridge #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tr_req(tr_req), .tr_data(tr_data),
    .tr_ack(tr_ack), .lv_req(lv_req), .lv_ack(lv_ack), .lv_data(lv_data)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Driver: one tr_req transition per word; expected word goes to the scoreboard.
  task automatic send(input logic [DW-1:0] d);
    logic a0;
    a0 = tr_ack;
    @(negedge clk);
    tr_data = d;
    tr_req = ~tr_req;
    exp_q.push_back(d);
    sent++;
    @(negedge clk);
    check(lv_req === 1'b1, "R2 lv_req after tr_req edge", lv_req, 1);
    tr_data = ~d ^ 8'h5A;  // disturb the input while the cycle runs
    for (int i = 0; i < 60 && tr_ack === a0; i++) @(negedge clk);
    check(tr_ack !== a0, "R4 tr_ack toggled per word", tr_ack, ~a0);
  endtask

  // Monitor / four-phase receiver model.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && lv_req) begin
        logic [DW-1:0] e;
        logic a0;
        int dly;
        dly = 1 + (served % 4);
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected lv_req", 1, 0);
          e = lv_data;
        end else e = exp_q.pop_front();
        check(lv_data === e, "R5 lv_data captured", lv_data, e);
        a0 = tr_ack;
        for (int i = 0; i < dly; i++) begin
          @(negedge clk);
          check(lv_req === 1'b1, "R3 lv_req held until ack", lv_req, 1);
          check(lv_data === e, "R5 lv_data stable", lv_data, e);
        end
        lv_ack = 1'b1;
        @(negedge clk);
        check(lv_req === 1'b0, "R3 lv_req falls after ack", lv_req, 0);
        check(tr_ack === a0, "R4 no tr_ack before rtz", tr_ack, a0);
        for (int i = 0; i < 2; i++) begin
          @(negedge clk);
          check(tr_ack === a0, "R4 tr_ack waits for lv_ack low", tr_ack, a0);
          check(lv_data === e, "R5 lv_data held through drop", lv_data, e);
        end
        lv_ack = 1'b0;
        @(negedge clk);
        check(tr_ack === ~a0, "R4 tr_ack toggles after rtz", tr_ack, ~a0);
        check(lv_req === 1'b0, "R7 no new cycle", lv_req, 0);
        served++;
      end
    end
  end

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        check(1'b0, "watchdog expired", cycles, 100000);
        finish_run();
      end
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(lv_req === 1'b0, "R1 lv_req in reset", lv_req, 0);
    check(tr_ack === 1'b0, "R1 tr_ack in reset", tr_ack, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(lv_req === 1'b0, "R1 lv_req after reset", lv_req, 0);

    // R7: steady tr_req starts nothing
    repeat (5) @(negedge clk);
    check(lv_req === 1'b0, "R7 steady tr_req", lv_req, 0);

    // R2/R4/R5: words on rising and falling edges
    send(8'hA5);
    send(8'h00);
    send(8'hFF);
    send(8'h3C);
    for (int k = 0; k < 6; k++) send(8'(k * 37 + 11));
    repeat (4) @(negedge clk);
    check(served == sent, "R2 one cycle per transition", served, sent);

    // R6: lv_ack pulses while idle
    begin
      logic a0;
      a0 = tr_ack;
      lv_ack = 1'b1;
      repeat (3) @(negedge clk);
      check(lv_req === 1'b0, "R6 idle ack no lv_req", lv_req, 0);
      check(tr_ack === a0, "R6 idle ack no tr_ack", tr_ack, a0);
      lv_ack = 1'b0;
      repeat (3) @(negedge clk);
      check(tr_ack === a0, "R6 idle ack release", tr_ack, a0);
      check(lv_req === 1'b0, "R6 idle ack release lv_req", lv_req, 0);
    end

    // R1: reset with tr_req high must not start a cycle
    @(negedge clk);
    rst_n = 1'b0;
    tr_req = 1'b1;
    repeat (2) @(negedge clk);
    check(tr_ack === 1'b0, "R1 tr_ack cleared", tr_ack, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(lv_req === 1'b0, "R1 no cycle with tr_req high", lv_req, 0);
    send(8'h96);  // falling edge after reset
    send(8'h69);
    repeat (4) @(negedge clk);
    check(served == sent, "R2 all words served", served, sent);
    check(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);

    finish_run();
  end

endmodule